// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block holds the digital half of a 10-bit successive-approximation converter. An external D-A stage turns the `dac_code` output into a comparison level. An external comparator returns `cmp_hi`, which is high when the analog input lies above that level. A conversion begins on a software start pulse or a hardware trigger pulse. It then resolves one result bit per comparison step, from the most significant bit down to the least significant. The D-A level for a nonzero code sits half an LSB below the code's nominal value (VREF/1024 × (code − 0.5)), and code zero means exactly 0 V.

Each comparison step lasts `STEP_CYCLES` clock cycles. This gives the D-A output and the comparator time to settle, and `cmp_hi` is sampled on the last cycle of the step. Single mode and scan mode each own a completion flag. The mode sampled at start picks which flag is cleared at start and set at the end. Channel stepping for scan mode belongs to logic outside this block. The result is a plain register output: it holds its value after completion until the next accepted start, and the one-cycle `done` pulse marks each new value. No handshake is needed, so no back-pressure applies.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A one-cycle high on `sw_start` or on `hw_trig` while `busy` is low starts a conversion, and `busy` is high from the next cycle.
- R2: In the first cycle of a conversion, `dac_code` equals 10'h200 (all bits cleared, then bit 9 set). The completion flag of the mode sampled at start (`scan_sel`=1 selects `scan_cmpl`, 0 selects `single_cmpl`) is 0, and the other flag is unchanged.
- R3: Each comparison step lasts exactly `STEP_CYCLES` clock cycles, and `dac_code` changes only at step boundaries.
- R4: At the end of a step the bit under test keeps the value 1 if `cmp_hi` is high and becomes 0 if it is low, and the next lower bit is set to 1 for the following step.
- R5: A conversion takes exactly ten steps. `done` goes high on the clock edge that ends the tenth step, 10×`STEP_CYCLES` cycles after the start edge, and it stays high for one cycle only.
- R6: In the cycle that `done` is high, `busy` is low and the completion flag of the active mode is 1.
- R7: A start request (software or hardware) seen while `busy` is high is ignored, including a request in the cycle in which the last bit is decided.
- R8: While idle and without a new start, `result` keeps its value, whatever `cmp_hi` does.
- R9: A synchronous reset gives `busy`=0, `done`=0, `result`=0 and both completion flags at 1.
- R10: With a comparator that follows the half-LSB-offset level, the final `result` is the largest code whose level lies below the input. This is 0 for an input at 0 V and 1023 at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_start | input | 1 | Software start request pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| scan_sel | input | 1 | Mode for the next conversion: 1 scan, 0 single |
| cmp_hi | input | 1 | Comparator: input above the D-A level |
| dac_code | output | 10 | Code driven to the D-A converter |
| result | output | 10 | Approximation register / conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the last bit is decided |
| single_cmpl | output | 1 | Single-mode completion flag |
| scan_cmpl | output | 1 | Scan-mode completion flag |

## Verification
Two functions can fall into one cycle. The first pair is a start request and the decision of the last bit. The bench provokes this by pulsing `sw_start` exactly on the edge that ends the tenth step. It then judges that `done` pulses once, that `busy` stays low afterwards, and that `result` keeps the value just decided instead of reloading 10'h200. The second pair is a software start and a hardware trigger arriving together. Random runs mix these with mid-conversion start pulses and with both modes. Each conversion must still last ten steps and end on the code the threshold model predicts.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_CONV = 1'b1
  } sar_phase_e;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_SCAN   = 1'b1
  } sar_mode_e;
endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int STEP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic tick
);
  generate
    if (STEP_CYCLES <= 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(STEP_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      assign tick = run && (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (rst || load) begin
          cnt_q <= '0;
        end else if (run) begin
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                step,
  input  logic                cmp,
  output logic [RES_BITS-1:0] code,
  output logic                at_lsb
);
  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(RES_BITS - 1);

  logic [RES_BITS-1:0] code_q, code_nxt;
  logic [IDX_W-1:0]    idx_q;

  always_comb begin
    code_nxt = code_q;
    for (int i = 0; i < RES_BITS; i++) begin
      if (IDX_W'(i) == idx_q) begin
        code_nxt[i] = cmp;
      end else if ((idx_q != '0) && (IDX_W'(i) == idx_q - 1'b1)) begin
        code_nxt[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      idx_q  <= TOP;
    end else if (load) begin
      code_q <= {1'b1, {(RES_BITS-1){1'b0}}};
      idx_q  <= TOP;
    end else if (step) begin
      code_q <= code_nxt;
      if (idx_q != '0) idx_q <= idx_q - 1'b1;
    end
  end

  assign code   = code_q;
  assign at_lsb = (idx_q == '0);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_adc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic mode_in,
  input  logic tick,
  input  logic at_lsb,
  output logic start,
  output logic busy,
  output logic done,
  output logic single_cmpl,
  output logic scan_cmpl
);
  sar_phase_e phase_q;
  sar_mode_e  mode_q;
  logic       finish;

  assign start  = (phase_q == PH_IDLE) && req;
  assign finish = (phase_q == PH_CONV) && tick && at_lsb;
  assign busy   = (phase_q == PH_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      mode_q      <= MODE_SINGLE;
      done        <= 1'b0;
      single_cmpl <= 1'b1;
      scan_cmpl   <= 1'b1;
    end else begin
      done <= 1'b0;
      if (start) begin
        phase_q <= PH_CONV;
        mode_q  <= sar_mode_e'(mode_in);
        if (mode_in) scan_cmpl   <= 1'b0;
        else         single_cmpl <= 1'b0;
      end else if (finish) begin
        phase_q <= PH_IDLE;
        done    <= 1'b1;
        if (mode_q == MODE_SCAN) scan_cmpl   <= 1'b1;
        else                     single_cmpl <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_BITS    = 10,
  parameter int STEP_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_start,
  input  logic                hw_trig,
  input  logic                scan_sel,
  input  logic                cmp_hi,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result,
  output logic                busy,
  output logic                done,
  output logic                single_cmpl,
  output logic                scan_cmpl
);
  logic start, tick, at_lsb;
  logic [RES_BITS-1:0] code;

  sar_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req(sw_start | hw_trig), .mode_in(scan_sel),
    .tick(tick), .at_lsb(at_lsb), .start(start), .busy(busy), .done(done),
    .single_cmpl(single_cmpl), .scan_cmpl(scan_cmpl)
  );

  sar_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .load(start), .run(busy), .tick(tick)
  );

  sar_approx_reg #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst(rst), .load(start), .step(tick), .cmp(cmp_hi),
    .code(code), .at_lsb(at_lsb)
  );

  assign dac_code = code;
  assign result   = code;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                sw_start,
  input logic                hw_trig,
  input logic [RES_BITS-1:0] dac_code,
  input logic [RES_BITS-1:0] result,
  input logic                busy,
  input logic                done,
  input logic                single_cmpl,
  input logic                scan_cmpl
);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  AST_START_MSB: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> dac_code == MSB_ONLY); // R2

  AST_START_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !(single_cmpl && scan_cmpl)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !sw_start && !hw_trig) |=> $stable(result)); // R8
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (.*);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  localparam int N   = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst, sw_start, hw_trig, scan_sel, cmp_hi;
  logic [N-1:0] dac_code, result;
  logic busy, done, single_cmpl, scan_cmpl;
  int   vin_h;              // input in half-LSB units
  int   checks = 0, fails = 0;
  logic exp_single = 1'b1, exp_scan = 1'b1;

  always #2 clk = ~clk;     // 250 MHz

  sar_adc_ctrl #(.RES_BITS(N), .STEP_CYCLES(DIV)) u_dut (
    .clk(clk), .rst(rst), .sw_start(sw_start), .hw_trig(hw_trig),
    .scan_sel(scan_sel), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .result(result), .busy(busy), .done(done),
    .single_cmpl(single_cmpl), .scan_cmpl(scan_cmpl)
  );

  function automatic logic above(int code, int v);
    if (code == 0) return v > 0;
    return v > (2 * code - 1);
  endfunction

  function automatic int expect_code(int v);
    int best = 0;
    for (int c = 1; c < 1024; c++) if (above(c, v)) best = c;
    return best;
  endfunction

  assign cmp_hi = above(int'(dac_code), vin_h);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // inject: negedge index (1-based after start) at which to pulse sw_start; 0 = none
  task automatic convert(int v, bit mode, int trig_sel, int inject);
    int n = 0, cur, prev;
    logic prev_other;
    vin_h = v;
    scan_sel = mode;
    sw_start = (trig_sel != 1);
    hw_trig  = (trig_sel != 0);
    prev_other = mode ? single_cmpl : scan_cmpl;
    @(negedge clk);
    sw_start = 0; hw_trig = 0; n = 1;
    chk(busy === 1'b1, "R1", busy, 1);
    chk(dac_code === 10'h200, "R2", dac_code, 'h200);
    chk((mode ? scan_cmpl : single_cmpl) === 1'b0, "R2", mode ? scan_cmpl : single_cmpl, 0);
    chk((mode ? single_cmpl : scan_cmpl) === prev_other, "R2", mode ? single_cmpl : scan_cmpl, prev_other);
    prev = int'(dac_code);
    while (!done && n < 20 * DIV) begin
      if (n == inject) sw_start = 1;
      @(negedge clk);
      sw_start = 0;
      n++;
      cur = int'(dac_code);
      if (cur != prev && !done) begin
        int k = (n - 1) / DIV;
        chk((n - 1) % DIV == 0, "R3", n, ((n - 1) / DIV) * DIV + 1);
        chk(cur[N-k] == above(prev, v), "R4", cur[N-k], above(prev, v));
        chk(cur[N-1-k] == 1'b1, "R4", cur[N-1-k], 1);
      end
      prev = cur;
    end
    chk(n == 10 * DIV + 1, "R5", n, 10 * DIV + 1);
    chk(busy === 1'b0, "R6", busy, 0);
    chk((mode ? scan_cmpl : single_cmpl) === 1'b1, "R6", mode ? scan_cmpl : single_cmpl, 1);
    chk(int'(result) == expect_code(v), "R10", result, expect_code(v));
    @(negedge clk);
    chk(done === 1'b0, "R5", done, 0);
    chk(busy === 1'b0, "R7", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int r;
    logic [N-1:0] held;
    void'($urandom(32'd4242));
    rst = 1; sw_start = 0; hw_trig = 0; scan_sel = 0; vin_h = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(result === '0, "R9", result, 0);
    chk(busy === 1'b0 && done === 1'b0, "R9", {busy, done}, 0);
    chk(single_cmpl === 1'b1 && scan_cmpl === 1'b1, "R9", {single_cmpl, scan_cmpl}, 3);

    convert(0, 0, 0, 0);                 // R10 zero input
    convert(2046, 1, 1, 0);              // R10 full scale, hw trigger
    convert(1024, 0, 2, 0);              // R1 both triggers together
    convert(2, 1, 0, 10);                // R7 start mid-conversion
    convert(1022, 0, 1, 10 * DIV);       // R7 start on the LSB decision edge
    held = result;
    chk(held == 10'd511, "R7", held, 511);

    vin_h = 0;                           // R8 idle hold under changing comparator
    repeat (5) begin
      vin_h = vin_h + 600;
      @(negedge clk);
      chk(result === held, "R8", result, held);
    end

    for (int i = 0; i < 30; i++) begin
      r = int'($urandom_range(1023, 0)) * 2;
      convert(r, 1'($urandom_range(1, 0)), int'($urandom_range(2, 0)),
              ($urandom_range(3, 0) == 0) ? int'($urandom_range(10 * DIV, 2)) : 0);
      repeat ($urandom_range(3, 0)) @(negedge clk);
    end
    summary();
  end
endmodule